// File: doc/BRIEF.md
# Serial EEPROM Access Master over I2C

This block is a command-driven I2C bus master for a serial EEPROM. A host presents a command (a sequential read of N bytes from a start address, or a single byte write) with its address, data and length, and pulses `start`. The block raises `busy`, runs the whole bus transaction on open-drain SCL and SDA enables, and ends with a one-cycle `done` pulse that carries the final status. Read data comes out one byte at a time, each with an `rvalid` strobe.

The word address is one byte or two bytes, selected per command. When it is two bytes, the high byte goes out first. A read first sets the address with a write-direction control byte. It then issues a repeated start and a read-direction control byte, and streams bytes until the count is reached. After a write the block waits one bus-free period and then polls the device with acknowledge polling until the internal write cycle ends. A millisecond counter built from the system clock bounds the polling, and the limit is compared only after a poll that was refused. A device that refuses any byte of a transfer ends the command with a missing-acknowledge status.

Top module: `i2c_eeprom_master`

## Requirements
- R1: Every transfer control byte is {4'b1010, DEV_SEL, rw}, with rw=0 for writes and address setup and rw=1 for reads. Every poll control byte is 8'b1010_0000.
- R2: With `addr2`=1 the block sends `addr[15:8]` and then `addr[7:0]`. With `addr2`=0 it sends only `addr[7:0]`.
- R3: A read returns exactly `rlen` bytes (an `rlen` of 0 is treated as 1), each with an `rvalid` pulse, in ascending address order. The master acknowledges every byte except the last, leaves the last one unacknowledged, and then sends a stop.
- R4: A write transfers `wdata` to the addressed location, so that a later read of that address returns it.
- R5: If the device leaves a control, address or data byte unacknowledged, the command is aborted with a stop. `done` then pulses with `err_nack`=1 and `err_timeout`=0, and an aborted write changes no location.
- R6: After a write stop, the block polls repeatedly, with a stop and a bus-free period after each refused poll. On the first acknowledged poll it sends a start and then a stop, and ends with both error flags at 0.
- R7: When a poll is refused and at least TIMEOUT_MS milliseconds (each MS_TICKS clocks) have passed since polling began, the block sends a stop and ends with `err_timeout`=1 and `err_nack`=0.
- R8: `busy` is high from the cycle after `start` is accepted until the cycle in which `done` pulses. A `start` while busy is ignored, so that command gives no extra `done` and no changed data.
- R9: After reset, `busy`, `done` and `rvalid` are 0 and both line enables are released (0).
- R10: Within a byte, SDA changes only while SCL is low. Start and stop conditions are the only SDA edges made while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted while idle |
| cmd_write | input | 1 | 1 = byte write, 0 = sequential read |
| addr2 | input | 1 | 1 = two-byte word address |
| addr | input | 16 | Word address |
| wdata | input | 8 | Byte to write |
| rlen | input | LENW | Number of bytes to read |
| sda_in | input | 1 | Sensed SDA line level |
| busy | output | 1 | Command in progress |
| rdata | output | 8 | Received byte |
| rvalid | output | 1 | One-cycle strobe for rdata |
| done | output | 1 | One-cycle end-of-command pulse |
| err_nack | output | 1 | Command aborted on a missing acknowledge |
| err_timeout | output | 1 | Write completion exceeded the limit |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest state to reach from the ports is a poll refused after the time limit has passed. This needs a device whose internal write cycle outlasts the limit. The bench's behavioural EEPROM has a programmable busy window, and the bench sets it either longer than the limit or to a few poll periods. Missing acknowledges are injected one byte position at a time through the same model. Address order and the acknowledge of the last byte are recorded from the bus itself.

// File: rtl/i2c_eeprom_master.sv
module i2c_eeprom_master #(
  parameter int QDIV = 63,
  parameter int MS_TICKS = 100000,
  parameter int TIMEOUT_MS = 30,
  parameter logic [2:0] DEV_SEL = 3'b000,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cmd_write,
  input  logic            addr2,
  input  logic [15:0]     addr,
  input  logic [7:0]      wdata,
  input  logic [LENW-1:0] rlen,
  input  logic            sda_in,
  output logic            busy,
  output logic [7:0]      rdata,
  output logic            rvalid,
  output logic            done,
  output logic            err_nack,
  output logic            err_timeout,
  output logic            scl_oe,
  output logic            sda_oe
);

  localparam int DW = $clog2(QDIV + 1);
  localparam int MW = $clog2(MS_TICKS + 1);
  localparam int TW = $clog2(TIMEOUT_MS + 1);

  typedef enum logic [3:0] {
    P_IDLE, P_START, P_CTRL, P_AH, P_AL, P_WD, P_RSTART, P_CTRLR,
    P_RD, P_STOP, P_FREE, P_PSTART, P_POLL, P_FSTART, P_DONE
  } phase_t;

  phase_t          ph;
  logic [DW-1:0]   div;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic            samp, sda_s1, sda_s2;
  logic [LENW-1:0] len_q;
  logic [15:0]     addr_q;
  logic            a2_q, wr_q;
  logic [7:0]      wd_q;
  logic            polling, fin;
  logic [MW-1:0]   msdiv;
  logic [TW-1:0]   msel;

  wire tick     = (div == DW'(QDIV - 1));
  wire sym_end  = tick && (q == 2'd3);
  wire is_start = (ph == P_START) || (ph == P_RSTART) || (ph == P_PSTART) || (ph == P_FSTART);
  wire is_stop  = (ph == P_STOP);
  wire is_rx    = (ph == P_RD);
  wire is_bit   = (ph == P_CTRL) || (ph == P_AH) || (ph == P_AL) || (ph == P_WD) ||
                  (ph == P_CTRLR) || is_rx || (ph == P_POLL);
  wire last_rx  = (len_q == LENW'(1));
  wire txv      = is_rx ? ((bitn == 4'd8) ? last_rx : 1'b1)
                        : ((bitn == 4'd8) ? 1'b1 : sh[7]);
  wire q_edge   = (q == 2'd0) || (q == 2'd3);

  assign busy   = (ph != P_IDLE);
  assign scl_oe = (is_bit || is_start) ? q_edge : (is_stop ? (q == 2'd0) : 1'b0);
  assign sda_oe = is_bit ? ~txv : is_start ? q[1] : is_stop ? ~q[1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE;
      div <= '0;
      q <= '0;
      bitn <= '0;
      sh <= '0;
      samp <= 1'b1;
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
      len_q <= '0;
      addr_q <= '0;
      a2_q <= 1'b0;
      wr_q <= 1'b0;
      wd_q <= '0;
      polling <= 1'b0;
      fin <= 1'b0;
      msdiv <= '0;
      msel <= '0;
      rdata <= '0;
      rvalid <= 1'b0;
      done <= 1'b0;
      err_nack <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      done <= 1'b0;
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;

      if (!polling) begin
        msdiv <= '0;
        msel <= '0;
      end else if (msdiv == MW'(MS_TICKS - 1)) begin
        msdiv <= '0;
        if (msel != TW'(TIMEOUT_MS)) msel <= msel + 1'b1;
      end else begin
        msdiv <= msdiv + 1'b1;
      end

      if (ph == P_IDLE) begin
        div <= '0;
        q <= '0;
        bitn <= '0;
        if (start) begin
          ph <= P_START;
          addr_q <= addr;
          a2_q <= addr2;
          wr_q <= cmd_write;
          wd_q <= wdata;
          len_q <= (rlen == '0) ? LENW'(1) : rlen;
          err_nack <= 1'b0;
          err_timeout <= 1'b0;
          polling <= 1'b0;
          fin <= 1'b0;
        end
      end else if (ph == P_DONE) begin
        done <= 1'b1;
        ph <= P_IDLE;
      end else begin
        if (tick) begin
          div <= '0;
          q <= q + 1'b1;
        end else begin
          div <= div + 1'b1;
        end

        if (tick && q == 2'd2 && is_bit) begin
          samp <= sda_s2;
          if (is_rx && bitn != 4'd8) sh <= {sh[6:0], sda_s2};
        end

        if (sym_end) begin
          if (is_bit && bitn != 4'd8) begin
            bitn <= bitn + 1'b1;
            if (!is_rx) sh <= {sh[6:0], 1'b0};
          end else begin
            bitn <= '0;
            case (ph)
              P_START: begin
                ph <= P_CTRL;
                sh <= {4'b1010, DEV_SEL, 1'b0};
              end
              P_CTRL, P_AH, P_AL, P_WD, P_CTRLR: begin
                if (samp) begin
                  err_nack <= 1'b1;
                  fin <= 1'b1;
                  ph <= P_STOP;
                end else begin
                  case (ph)
                    P_CTRL: begin
                      ph <= a2_q ? P_AH : P_AL;
                      sh <= a2_q ? addr_q[15:8] : addr_q[7:0];
                    end
                    P_AH: begin
                      ph <= P_AL;
                      sh <= addr_q[7:0];
                    end
                    P_AL: begin
                      ph <= wr_q ? P_WD : P_RSTART;
                      sh <= wd_q;
                    end
                    P_WD: begin
                      polling <= 1'b1;
                      ph <= P_STOP;
                    end
                    default: ph <= P_RD;
                  endcase
                end
              end
              P_RSTART: begin
                ph <= P_CTRLR;
                sh <= {4'b1010, DEV_SEL, 1'b1};
              end
              P_RD: begin
                rvalid <= 1'b1;
                rdata <= sh;
                if (last_rx) begin
                  fin <= 1'b1;
                  ph <= P_STOP;
                end else begin
                  len_q <= len_q - 1'b1;
                end
              end
              P_POLL: begin
                if (!samp) begin
                  ph <= P_FSTART;
                end else if (msel >= TW'(TIMEOUT_MS)) begin
                  err_timeout <= 1'b1;
                  fin <= 1'b1;
                  polling <= 1'b0;
                  ph <= P_STOP;
                end else begin
                  ph <= P_STOP;
                end
              end
              P_FSTART: begin
                fin <= 1'b1;
                polling <= 1'b0;
                ph <= P_STOP;
              end
              P_STOP: ph <= P_FREE;
              P_FREE: begin
                if (fin) begin
                  ph <= P_DONE;
                end else begin
                  ph <= P_PSTART;
                end
              end
              P_PSTART: begin
                ph <= P_POLL;
                sh <= 8'b1010_0000;
              end
              default: ph <= P_IDLE;
            endcase
          end
        end
      end
    end
  end

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bit && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  a_r3_rvalid_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wd_q)));

  a_r5_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_nack && err_timeout));

endmodule

// File: tb/test_i2c_eeprom_master.sv
module test_i2c_eeprom_master;
  localparam logic [2:0] DSEL = 3'b101;
  localparam int TMO = 4;
  localparam int MST = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cmd_write = 1'b0, addr2 = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rlen = '0;
  logic busy, rvalid, done, err_nack, err_timeout, scl_oe, sda_oe;
  logic [7:0] rdata;
  logic m_pull = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || m_pull);

  always #2 clk = ~clk;

  i2c_eeprom_master #(.QDIV(2), .MS_TICKS(MST), .TIMEOUT_MS(TMO), .DEV_SEL(DSEL), .LENW(8)) i_i2c_eeprom_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write), .addr2(addr2),
    .addr(addr), .wdata(wdata), .rlen(rlen), .sda_in(sda), .busy(busy), .rdata(rdata),
    .rvalid(rvalid), .done(done), .err_nack(err_nack), .err_timeout(err_timeout),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  int vectors = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] rbuf [16];
  int rcnt = 0, ndone = 0;
  int cyc = 0, busy_until = 0, wr_busy = 0, nack_at = -1;
  int polls = 0, badctl = 0, glitch = 0, macks = 0, stop_cyc = 0;
  logic m_a2 = 1'b0;
  logic [7:0] rec_hi = '0;
  logic ps = 1'b1, pd = 1'b1, act = 1'b0, rdm = 1'b0, snd = 1'b0, first = 1'b0, mack = 1'b0;
  logic wpend = 1'b0, ack = 1'b0, np = 1'b0;
  logic [7:0] sr = '0, outb = '0, ptr = '0, wval = '0;
  int bitc = 0, bytei = 0;

  always @(negedge clk) begin
    cyc++;
    if (act && ps && !scl) begin
      if (bitc == 8 && !snd) begin
        ack = 1'b1;
        if (bytei == 0) begin
          if (sr[7:4] != 4'b1010) badctl++;
          if (sr[3:1] == 3'b000) begin
            if (sr[0]) badctl++;
            polls++;
          end else if (sr[3:1] != DSEL) badctl++;
          if (cyc < busy_until) ack = 1'b0;
        end
        if (nack_at == bytei) ack = 1'b0;
        if (bytei != 0 && !rdm && ack) begin
          if (m_a2 && bytei == 1) rec_hi = sr;
          else if ((m_a2 && bytei == 2) || (!m_a2 && bytei == 1)) ptr = sr;
          else begin wpend = 1'b1; wval = sr; end
        end
        if (bytei == 0 && ack && sr[0]) begin rdm = 1'b1; first = 1'b1; end
        np = ack;
      end else if (bitc == 9) begin
        bitc = 0;
        bytei++;
        np = 1'b0;
        if (snd && mack) macks++;
        if (rdm && (first || (snd && mack))) begin
          outb = mem[ptr]; ptr = ptr + 8'd1; snd = 1'b1; first = 1'b0; np = !outb[7];
        end else snd = 1'b0;
      end else if (snd && bitc >= 1 && bitc <= 7) np = !outb[7-bitc];
      else if (snd && bitc == 8) np = 1'b0;
    end else if (ps && scl && pd && !sda) begin
      if (act && bitc >= 2) glitch++;
      act = 1'b1; bitc = 0; bytei = 0; rdm = 1'b0; snd = 1'b0; np = 1'b0; wpend = 1'b0;
    end else if (ps && scl && !pd && sda) begin
      if (act && bitc >= 2) glitch++;
      act = 1'b0; np = 1'b0;
      if (wpend) begin
        mem[ptr] = wval; busy_until = cyc + wr_busy; stop_cyc = cyc; wpend = 1'b0;
      end
    end else if (act && !ps && scl) begin
      bitc++;
      if (bitc <= 8 && !snd) sr = {sr[6:0], sda};
      if (bitc == 9 && snd) mack = !sda;
    end
    ps = scl; pd = sda;
    m_pull = np;
  end

  always @(negedge clk) begin
    if (rvalid) begin
      if (rcnt < 16) rbuf[rcnt] <= rdata;
      rcnt <= rcnt + 1;
    end
    if (done) ndone <= ndone + 1;
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    vectors++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  logic f_nack, f_to;
  int t_done;

  task automatic run(input logic w, input logic a2, input logic [15:0] a, input logic [7:0] d,
                     input logic [7:0] n, input logic inject);
    int k;
    @(negedge clk);
    rcnt = 0; ndone = 0; macks = 0; polls = 0; m_a2 = a2;
    cmd_write = w; addr2 = a2; addr = a; wdata = d; rlen = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after accept", int'(busy), 1);
    k = 0;
    while (!done && k < 20000) begin
      if (inject && k == 30) begin cmd_write = ~w; addr = ~a; start = 1'b1; end
      if (inject && k == 31) start = 1'b0;
      @(negedge clk);
      k++;
    end
    if (k >= 20000) begin fails++; $display("FAIL R8: command hung, actual 0 expected 1"); end
    f_nack = err_nack; f_to = err_timeout; t_done = cyc;
    check("R8 busy low at done", int'(busy), 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic do_read(input logic a2, input logic [15:0] a, input int n, input logic inject);
    run(1'b0, a2, a, 8'h00, 8'(n), inject);
    check("R3 byte count", rcnt, (n == 0) ? 1 : n);
    check("R3 master acks", macks, ((n == 0) ? 1 : n) - 1);
    check("R5 no error on read", int'({f_nack, f_to}), 0);
    check("R8 single done", ndone, 1);
    for (int i = 0; i < ((n == 0) ? 1 : n); i++)
      check("R3 read data", int'(rbuf[i]), int'(expm[8'(a[7:0] + 8'(i))]));
    if (a2) check("R2 high byte first", int'(rec_hi), int'(a[15:8]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 37 + 11); expm[i] = 8'(i * 37 + 11); end
    repeat (3) @(negedge clk);
    check("R9 busy at reset", int'(busy), 0);
    check("R9 lines at reset", int'({scl_oe, sda_oe}), 0);
    check("R9 strobes at reset", int'({done, rvalid}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int a2 = 0; a2 < 2; a2++)
      for (int n = 1; n <= 4; n++)
        for (int b = 0; b < 3; b++)
          do_read(1'(a2), {8'(8'h5A + n + b), 8'(b * 100 + 3 + (b == 2 ? 50 : 0))}, n, 1'b0);
    do_read(1'b0, 16'h00FE, 0, 1'b0);
    do_read(1'b1, 16'h33FF, 3, 1'b0);

    wr_busy = 0;
    run(1'b1, 1'b0, 16'h0010, 8'hC3, 8'd0, 1'b0);
    expm[8'h10] = 8'hC3;
    check("R6 write ok", int'({f_nack, f_to}), 0);
    check("R1 poll byte seen", polls, 1);
    do_read(1'b0, 16'h0010, 1, 1'b0);
    check("R4 write readback", int'(rbuf[0]), 8'hC3);

    wr_busy = 300;
    run(1'b1, 1'b1, 16'h7722, 8'h5E, 8'd0, 1'b0);
    expm[8'h22] = 8'h5E;
    check("R6 write ok after polling", int'({f_nack, f_to}), 0);
    check("R6 repeated polls", int'(polls > 1), 1);
    do_read(1'b1, 16'h7722, 2, 1'b0);
    check("R4 write readback 2-byte", int'(rbuf[0]), 8'h5E);

    wr_busy = 100000;
    run(1'b1, 1'b0, 16'h0040, 8'hA5, 8'd0, 1'b0);
    expm[8'h40] = 8'hA5;
    check("R7 timeout flag", int'({f_nack, f_to}), 1);
    check("R7 not before limit", int'((t_done - stop_cyc) >= TMO * MST - 10), 1);
    check("R7 soon after limit", int'((t_done - stop_cyc) <= TMO * MST + 160), 1);
    busy_until = 0;
    wr_busy = 0;

    for (int a2 = 0; a2 < 2; a2++)
      for (int p = 0; p < 3 + a2; p++) begin
        nack_at = p;
        run(1'b1, 1'(a2), 16'h2050, 8'h99, 8'd0, 1'b0);
        nack_at = -1;
        check("R5 nack flag", int'({f_nack, f_to}), 2);
        do_read(1'(a2), 16'h2050, 1, 1'b0);
        check("R5 location unchanged", int'(rbuf[0]), int'(expm[8'h50]));
      end
    nack_at = 1;
    run(1'b0, 1'b0, 16'h0005, 8'h00, 8'd2, 1'b0);
    nack_at = -1;
    check("R5 read abort flag", int'({f_nack, f_to}), 2);
    check("R5 read abort no data", rcnt, 0);

    do_read(1'b1, 16'h1188, 3, 1'b1);
    check("R8 ignored start left bus idle", int'(busy), 0);

    check("R1 control byte format", badctl, 0);
    check("R10 sda edges under scl high", glitch, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule